// File: doc/BRIEF.md
# Segmented Virtual Address Decoder with Fault Capture

This block takes a 32-bit virtual address and decides how it is translated. The top three address bits select a segment. The current privilege mode and the error-level flag then decide the outcome. There are three possible results:
- a direct physical address with write permission,
- a request to an external TLB lookup, or
- an address fault.

The block accepts the TLB's result code in the same cycle as the request. It combines a faulting outcome with the access type (load, store or fetch) and produces an exception code and a refill flag.

When the processor commits a fault, it pulses a strobe. On that clock edge three fault registers load new values:
- the bad virtual address;
- a context word, built from a page-table base input and the faulting virtual page number;
- an entry-high word, built from the faulting page address and the current ASID input.

The TLB array and the exception vectoring are outside this block.

Top module: `seg_addr_decoder`

## Requirements
- R1: An address with bit 31 clear, with `err_level` high, passes through unchanged. `phys_valid`=1, `wr_ok`=1, `tlb_req`=0, and no fault, in every mode.
- R2: An address with bit 31 clear, with `err_level` low, raises `tlb_req`=1 and keeps `phys_valid`=0 in every mode.
- R3: Addresses 0x80000000–0x9FFFFFFF in kernel mode (mode 0) give `phys_addr` = address − 0x80000000, with `phys_valid`=1 and `wr_ok`=1. In any other mode they fault as a bad address.
- R4: Addresses 0xA0000000–0xBFFFFFFF in kernel mode give `phys_addr` = address − 0xA0000000, with `phys_valid`=1 and `wr_ok`=1. In any other mode they fault as a bad address.
- R5: Addresses 0xC0000000–0xDFFFFFFF raise `tlb_req` in kernel or supervisor mode (mode 1). In user mode (mode 2) they fault as a bad address.
- R6: Addresses 0xE0000000 and above raise `tlb_req` in kernel mode only. In supervisor or user mode they fault as a bad address.
- R7: The access type is encoded as 0 = load, 1 = store, 2 = fetch. A bad-address fault gives `exc_code` 5 for a store and 4 otherwise, with `refill`=0.
- R8: The TLB result is encoded as 0 = hit, 1 = no match, 2 = invalid, 3 = modified. It is used only while `tlb_req`=1.
  - A hit gives no fault.
  - No match gives `exc_code` 3 for a store and 2 otherwise, with `refill`=1.
  - Invalid gives the same codes as no match, with `refill`=0.
  - Modified gives `exc_code` 1.
- R9: On a clock edge where `fault_strobe`=1 and `exc_valid`=1, the fault registers load:
  - `badvaddr_q` = the address;
  - `context_q` = {`ptbase`[8:0], address[31:13], 4'b0};
  - `entryhi_q` = {address[31:13], 5'b0, `asid`}.
- R10: The fault registers reset to zero. They keep their value on any edge where `fault_strobe` is low or no fault is present.
- R11: Mode value 3 behaves exactly like user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vaddr | input | 32 | Virtual address |
| mode | input | 2 | Privilege mode: 0 kernel, 1 supervisor, 2/3 user |
| err_level | input | 1 | Error-level flag; bypasses translation of the low segment |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| tlb_res | input | 2 | TLB result for the current request |
| asid | input | 8 | Current address-space identifier |
| ptbase | input | 9 | Page-table base bits for the context word |
| fault_strobe | input | 1 | Commits the current fault into the registers |
| phys_addr | output | 32 | Direct physical address (zero when not direct) |
| phys_valid | output | 1 | Direct translation produced |
| wr_ok | output | 1 | Write permitted on the direct path |
| tlb_req | output | 1 | Address forwarded to the TLB |
| bad_addr | output | 1 | Segment not allowed in this mode |
| exc_valid | output | 1 | A fault is present |
| exc_code | output | 5 | Exception code of the fault |
| refill | output | 1 | Fault is a TLB miss needing refill |
| badvaddr_q | output | 32 | Captured faulting address |
| context_q | output | 32 | Captured context word |
| entryhi_q | output | 32 | Captured entry-high word |

## Verification
The bench builds the block with its defaults: a 32-bit address, 13-bit page shift, 8-bit ASID and the supervisor segment enabled. With these values every segment boundary and every mode lies within reach. So do the full mapping from TLB result to exception code and the exact bit placement of the context and entry-high words. It probes the first and last address of each segment, including the change of bit 31 at 0x7FFFFFFF/0x80000000. It also steps the fault strobe with and without a fault present, to show that the registers change only when both are set.

// File: rtl/sad_pkg.sv
package sad_pkg;
   typedef enum logic [1:0] {
      MD_KERNEL = 2'd0,
      MD_SUPV   = 2'd1,
      MD_USER   = 2'd2,
      MD_USER_A = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      AC_LOAD  = 2'd0,
      AC_STORE = 2'd1,
      AC_FETCH = 2'd2,
      AC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      TR_HIT     = 2'd0,
      TR_NOMATCH = 2'd1,
      TR_INVALID = 2'd2,
      TR_MOD     = 2'd3
   } tlbres_e;

   typedef enum logic [2:0] {
      SG_USER, SG_KUNC_C, SG_KUNC_U, SG_SUPV, SG_KMAP
   } seg_e;

   localparam logic [4:0] EX_MOD  = 5'd1;
   localparam logic [4:0] EX_TLBL = 5'd2;
   localparam logic [4:0] EX_TLBS = 5'd3;
   localparam logic [4:0] EX_ADEL = 5'd4;
   localparam logic [4:0] EX_ADES = 5'd5;
endpackage

// File: rtl/sad_seg_classify.sv
module sad_seg_classify
   import sad_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter bit SUPV_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [1:0]        mode,
   input  logic              err_level,
   output seg_e              seg,
   output logic [ADDR_W-1:0] phys_addr,
   output logic              phys_valid,
   output logic              tlb_req,
   output logic              bad_addr
);
   localparam int OFS_W = ADDR_W - 3;

   logic is_kern;
   logic sup_ok;

   assign is_kern = (mode == MD_KERNEL);

   generate
      if (SUPV_EN) begin : g_supv
         assign sup_ok = is_kern | (mode == MD_SUPV);
      end else begin : g_nosupv
         assign sup_ok = is_kern;
      end
   endgenerate

   always_comb begin
      seg        = SG_USER;
      phys_addr  = '0;
      phys_valid = 1'b0;
      tlb_req    = 1'b0;
      bad_addr   = 1'b0;
      unique casez (vaddr[ADDR_W-1 -: 3])
         3'b0??: begin
            seg = SG_USER;
            if (err_level) begin
               phys_addr  = vaddr;
               phys_valid = 1'b1;
            end else begin
               tlb_req = 1'b1;
            end
         end
         3'b100, 3'b101: begin
            seg = vaddr[ADDR_W-3] ? SG_KUNC_U : SG_KUNC_C;
            if (is_kern) begin
               phys_addr  = {3'b000, vaddr[OFS_W-1:0]};
               phys_valid = 1'b1;
            end else begin
               bad_addr = 1'b1;
            end
         end
         3'b110: begin
            seg      = SG_SUPV;
            tlb_req  = sup_ok;
            bad_addr = !sup_ok;
         end
         default: begin
            seg      = SG_KMAP;
            tlb_req  = is_kern;
            bad_addr = !is_kern;
         end
      endcase
   end
endmodule

// File: rtl/sad_fault_map.sv
module sad_fault_map
   import sad_pkg::*;
(
   input  logic       bad_addr,
   input  logic       tlb_req,
   input  logic [1:0] tlb_res,
   input  logic [1:0] acc_type,
   output logic       exc_valid,
   output logic [4:0] exc_code,
   output logic       refill
);
   logic is_store;
   assign is_store = (acc_type == AC_STORE);

   always_comb begin
      exc_valid = 1'b0;
      exc_code  = '0;
      refill    = 1'b0;
      if (bad_addr) begin
         exc_valid = 1'b1;
         exc_code  = is_store ? EX_ADES : EX_ADEL;
      end else if (tlb_req) begin
         unique case (tlb_res)
            TR_HIT: ;
            TR_NOMATCH: begin
               exc_valid = 1'b1;
               exc_code  = is_store ? EX_TLBS : EX_TLBL;
               refill    = 1'b1;
            end
            TR_INVALID: begin
               exc_valid = 1'b1;
               exc_code  = is_store ? EX_TLBS : EX_TLBL;
            end
            default: begin
               exc_valid = 1'b1;
               exc_code  = EX_MOD;
            end
         endcase
      end
   end
endmodule

// File: rtl/sad_fault_regs.sv
module sad_fault_regs #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 13,
   parameter int ASID_W     = 8,
   parameter int CTX_LSB    = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   capture,
   input  logic [ADDR_W-1:0]                      vaddr,
   input  logic [ASID_W-1:0]                      asid,
   input  logic [ADDR_W-(ADDR_W-PAGE_SHIFT)-CTX_LSB-1:0] ptbase,
   output logic [ADDR_W-1:0]                      badvaddr_q,
   output logic [ADDR_W-1:0]                      context_q,
   output logic [ADDR_W-1:0]                      entryhi_q
);
   localparam int VPN_W = ADDR_W - PAGE_SHIFT;
   localparam int GAP_W = PAGE_SHIFT - ASID_W;

   logic [VPN_W-1:0] vpn;
   assign vpn = vaddr[ADDR_W-1:PAGE_SHIFT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         badvaddr_q <= '0;
         context_q  <= '0;
         entryhi_q  <= '0;
      end else if (capture) begin
         badvaddr_q <= vaddr;
         context_q  <= {ptbase, vpn, {CTX_LSB{1'b0}}};
         entryhi_q  <= {vpn, {GAP_W{1'b0}}, asid};
      end
   end
endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder
   import sad_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 13,
   parameter int ASID_W     = 8,
   parameter int CTX_LSB    = 4,
   parameter bit SUPV_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       vaddr,
   input  logic [1:0]        mode,
   input  logic              err_level,
   input  logic [1:0]        acc_type,
   input  logic [1:0]        tlb_res,
   input  logic [7:0]        asid,
   input  logic [8:0]        ptbase,
   input  logic              fault_strobe,
   output logic [31:0]       phys_addr,
   output logic              phys_valid,
   output logic              wr_ok,
   output logic              tlb_req,
   output logic              bad_addr,
   output logic              exc_valid,
   output logic [4:0]        exc_code,
   output logic              refill,
   output logic [31:0]       badvaddr_q,
   output logic [31:0]       context_q,
   output logic [31:0]       entryhi_q
);
   localparam int VPN_W = ADDR_W - PAGE_SHIFT;
   localparam int PTB_W = ADDR_W - VPN_W - CTX_LSB;

   generate
      if (ADDR_W != 32) begin : g_chk_aw
         $error("seg_addr_decoder: ADDR_W must be 32");
      end
      if (PAGE_SHIFT < ASID_W || ASID_W != 8) begin : g_chk_asid
         $error("seg_addr_decoder: ASID must be 8 bits and fit below the page shift");
      end
      if (PTB_W != 9) begin : g_chk_ptb
         $error("seg_addr_decoder: page-table base width must be 9");
      end
   endgenerate

   seg_e seg;

   sad_seg_classify #(.ADDR_W(ADDR_W), .SUPV_EN(SUPV_EN)) u_cls (
      .vaddr      (vaddr),
      .mode       (mode),
      .err_level  (err_level),
      .seg        (seg),
      .phys_addr  (phys_addr),
      .phys_valid (phys_valid),
      .tlb_req    (tlb_req),
      .bad_addr   (bad_addr)
   );

   assign wr_ok = phys_valid;

   sad_fault_map u_map (
      .bad_addr  (bad_addr),
      .tlb_req   (tlb_req),
      .tlb_res   (tlb_res),
      .acc_type  (acc_type),
      .exc_valid (exc_valid),
      .exc_code  (exc_code),
      .refill    (refill)
   );

   sad_fault_regs #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
      .ASID_W(ASID_W), .CTX_LSB(CTX_LSB)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (fault_strobe & exc_valid),
      .vaddr      (vaddr),
      .asid       (asid),
      .ptbase     (ptbase),
      .badvaddr_q (badvaddr_q),
      .context_q  (context_q),
      .entryhi_q  (entryhi_q)
   );
endmodule

// File: rtl/seg_addr_decoder_chk.sv
module seg_addr_decoder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] vaddr,
   input logic [1:0]  mode,
   input logic        fault_strobe,
   input logic [31:0] phys_addr,
   input logic        phys_valid,
   input logic        tlb_req,
   input logic        bad_addr,
   input logic        exc_valid,
   input logic [4:0]  exc_code,
   input logic        refill,
   input logic [31:0] badvaddr_q
);
   // R1 R2 R3
   outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({phys_valid, tlb_req, bad_addr}));

   // R3 R4
   unmapped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phys_valid && vaddr[31]) |-> (phys_addr[31:29] == 3'b000));

   // R11
   user_high_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && vaddr[31]) |-> bad_addr);

   // R8
   refill_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refill |-> (exc_valid && (exc_code == 5'd2 || exc_code == 5'd3)));

   // R9
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_strobe && exc_valid) |=> (badvaddr_q == $past(vaddr)));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_strobe && exc_valid) |=> $stable(badvaddr_q));
endmodule

bind seg_addr_decoder seg_addr_decoder_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .vaddr        (vaddr),
   .mode         (mode),
   .fault_strobe (fault_strobe),
   .phys_addr    (phys_addr),
   .phys_valid   (phys_valid),
   .tlb_req      (tlb_req),
   .bad_addr     (bad_addr),
   .exc_valid    (exc_valid),
   .exc_code     (exc_code),
   .refill       (refill),
   .badvaddr_q   (badvaddr_q)
);

// File: tb/seg_addr_decoder_bench.sv
module seg_addr_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] vaddr = '0;
   logic [1:0]  mode = 2'd0;
   logic        err_level = 1'b0;
   logic [1:0]  acc_type = 2'd0;
   logic [1:0]  tlb_res = 2'd0;
   logic [7:0]  asid = '0;
   logic [8:0]  ptbase = '0;
   logic        fault_strobe = 1'b0;
   logic [31:0] phys_addr;
   logic        phys_valid, wr_ok, tlb_req, bad_addr, exc_valid, refill;
   logic [4:0]  exc_code;
   logic [31:0] badvaddr_q, context_q, entryhi_q;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   seg_addr_decoder u_seg_addr_decoder (
      .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .mode(mode),
      .err_level(err_level), .acc_type(acc_type), .tlb_res(tlb_res),
      .asid(asid), .ptbase(ptbase), .fault_strobe(fault_strobe),
      .phys_addr(phys_addr), .phys_valid(phys_valid), .wr_ok(wr_ok),
      .tlb_req(tlb_req), .bad_addr(bad_addr), .exc_valid(exc_valid),
      .exc_code(exc_code), .refill(refill), .badvaddr_q(badvaddr_q),
      .context_q(context_q), .entryhi_q(entryhi_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] va, input logic [1:0] md, input logic erl,
                        input logic [1:0] ac, input logic [1:0] tr);
      @(negedge clk);
      vaddr = va; mode = md; err_level = erl; acc_type = ac; tlb_res = tr;
      #2;
   endtask

   // outcome bundle: {phys_valid, wr_ok, tlb_req, bad_addr, exc_valid}
   function automatic logic [31:0] flags();
      return {27'd0, phys_valid, wr_ok, tlb_req, bad_addr, exc_valid};
   endfunction

   task automatic t_reset();
      chk("R10 reset badvaddr", badvaddr_q, 32'h0);
      chk("R10 reset context", context_q, 32'h0);
      chk("R10 reset entryhi", entryhi_q, 32'h0);
   endtask

   task automatic t_user_erl();
      for (int m = 0; m < 4; m++) begin
         apply(32'h7FFF_FFFF, m[1:0], 1'b1, 2'd1, 2'd1);
         chk("R1 erl pass addr", phys_addr, 32'h7FFF_FFFF);
         chk("R1 erl flags", flags(), 32'b11000);
      end
      apply(32'h0000_0000, 2'd2, 1'b1, 2'd0, 2'd0);
      chk("R1 erl zero addr", phys_addr, 32'h0);
   endtask

   task automatic t_user_tlb();
      for (int m = 0; m < 4; m++) begin
         apply(32'h0040_1000, m[1:0], 1'b0, 2'd0, 2'd0);
         chk("R2 user tlb flags", flags(), 32'b00100);
      end
   endtask

   task automatic t_kseg0();
      apply(32'h8000_0000, 2'd0, 1'b0, 2'd0, 2'd0);
      chk("R3 kseg0 low", phys_addr, 32'h0);
      chk("R3 kseg0 flags", flags(), 32'b11000);
      apply(32'h9FFF_FFFC, 2'd0, 1'b1, 2'd1, 2'd0);
      chk("R3 kseg0 high", phys_addr, 32'h1FFF_FFFC);
      apply(32'h8123_4560, 2'd1, 1'b0, 2'd0, 2'd0);
      chk("R3 kseg0 supv bad", flags(), 32'b00011);
   endtask

   task automatic t_kseg1();
      apply(32'hA000_0010, 2'd0, 1'b0, 2'd0, 2'd0);
      chk("R4 kseg1 low", phys_addr, 32'h0000_0010);
      chk("R4 kseg1 flags", flags(), 32'b11000);
      apply(32'hBFFF_FFFF, 2'd0, 1'b0, 2'd2, 2'd0);
      chk("R4 kseg1 high", phys_addr, 32'h1FFF_FFFF);
      apply(32'hB000_0000, 2'd2, 1'b0, 2'd0, 2'd0);
      chk("R4 kseg1 user bad", flags(), 32'b00011);
   endtask

   task automatic t_sseg();
      apply(32'hC000_0000, 2'd0, 1'b0, 2'd0, 2'd0);
      chk("R5 sseg kernel", flags(), 32'b00100);
      apply(32'hDFFF_FFFF, 2'd1, 1'b0, 2'd0, 2'd0);
      chk("R5 sseg supv", flags(), 32'b00100);
      apply(32'hC800_0000, 2'd2, 1'b0, 2'd0, 2'd0);
      chk("R5 sseg user bad", flags(), 32'b00011);
   endtask

   task automatic t_kseg3();
      apply(32'hE000_0000, 2'd0, 1'b0, 2'd0, 2'd0);
      chk("R6 kseg3 kernel", flags(), 32'b00100);
      apply(32'hFFFF_FFFF, 2'd1, 1'b0, 2'd0, 2'd0);
      chk("R6 kseg3 supv bad", flags(), 32'b00011);
      apply(32'hF000_0000, 2'd2, 1'b0, 2'd0, 2'd0);
      chk("R6 kseg3 user bad", flags(), 32'b00011);
   endtask

   task automatic t_badcodes();
      apply(32'h8000_0000, 2'd2, 1'b0, 2'd1, 2'd0);
      chk("R7 store code", {27'd0, exc_code}, 32'd5);
      chk("R7 refill clear", {31'd0, refill}, 32'd0);
      apply(32'h8000_0000, 2'd2, 1'b0, 2'd0, 2'd0);
      chk("R7 load code", {27'd0, exc_code}, 32'd4);
      apply(32'hE000_0000, 2'd1, 1'b0, 2'd2, 2'd1);
      chk("R7 fetch code", {27'd0, exc_code}, 32'd4);
   endtask

   task automatic t_tlbcodes();
      apply(32'h0000_2000, 2'd2, 1'b0, 2'd0, 2'd0);
      chk("R8 hit no fault", {31'd0, exc_valid}, 32'd0);
      apply(32'h0000_2000, 2'd2, 1'b0, 2'd1, 2'd1);
      chk("R8 nomatch store", {26'd0, refill, exc_code}, {26'd0, 1'b1, 5'd3});
      apply(32'h0000_2000, 2'd2, 1'b0, 2'd0, 2'd1);
      chk("R8 nomatch load", {26'd0, refill, exc_code}, {26'd0, 1'b1, 5'd2});
      apply(32'hC000_2000, 2'd1, 1'b0, 2'd1, 2'd2);
      chk("R8 invalid store", {26'd0, refill, exc_code}, {26'd0, 1'b0, 5'd3});
      apply(32'hC000_2000, 2'd1, 1'b0, 2'd2, 2'd2);
      chk("R8 invalid fetch", {26'd0, refill, exc_code}, {26'd0, 1'b0, 5'd2});
      apply(32'hE000_2000, 2'd0, 1'b0, 2'd1, 2'd3);
      chk("R8 modified", {26'd0, refill, exc_code}, {26'd0, 1'b0, 5'd1});
      apply(32'h8000_2000, 2'd0, 1'b0, 2'd1, 2'd1);
      chk("R8 tlb result ignored off path", {31'd0, exc_valid}, 32'd0);
   endtask

   task automatic t_capture();
      logic [31:0] va;
      va = 32'h1234_5678;
      @(negedge clk);
      vaddr = va; mode = 2'd2; err_level = 1'b0; acc_type = 2'd0; tlb_res = 2'd1;
      asid = 8'h5A; ptbase = 9'h1FF; fault_strobe = 1'b1;
      @(negedge clk);
      fault_strobe = 1'b0;
      #2;
      chk("R9 badvaddr", badvaddr_q, va);
      chk("R9 context", context_q, {9'h1FF, va[31:13], 4'h0});
      chk("R9 entryhi", entryhi_q, {va[31:13], 5'h0, 8'h5A});
   endtask

   task automatic t_nocapture();
      @(negedge clk);
      vaddr = 32'h8000_4000; mode = 2'd0; err_level = 1'b0; tlb_res = 2'd1;
      asid = 8'h11; ptbase = 9'h003; fault_strobe = 1'b1;
      @(negedge clk);
      fault_strobe = 1'b0;
      #2;
      chk("R10 strobe without fault", badvaddr_q, 32'h1234_5678);
      @(negedge clk);
      vaddr = 32'hF000_0000; mode = 2'd2;
      @(negedge clk);
      #2;
      chk("R10 fault without strobe", badvaddr_q, 32'h1234_5678);
      chk("R10 entryhi held", entryhi_q, 32'h1234_405A);
   endtask

   task automatic t_mode3();
      apply(32'hC000_0000, 2'd3, 1'b0, 2'd1, 2'd0);
      chk("R11 mode3 sseg bad", flags(), 32'b00011);
      chk("R11 mode3 code", {27'd0, exc_code}, 32'd5);
      apply(32'hA000_0000, 2'd3, 1'b0, 2'd0, 2'd0);
      chk("R11 mode3 kseg1 bad", flags(), 32'b00011);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2;
      t_reset();
      rst_n = 1'b1;
      t_user_erl();
      t_user_tlb();
      t_kseg0();
      t_kseg1();
      t_sseg();
      t_kseg3();
      t_badcodes();
      t_tlbcodes();
      t_capture();
      t_nocapture();
      t_mode3();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule